// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Engine

This block is the device end of an Ultra DMA data-in transfer on a parallel ATA-style disk bus. It takes 16-bit words from a local ready/valid source and hands them to the host in a burst. The block first raises its DMA request and waits for the host's acknowledge. It then drives one word on the data lines for every transition of its strobe, both rising and falling. The minimum spacing between strobe transitions is worked out from the system clock period and the timing of the selected transfer mode.

The host can throttle the burst by dropping its ready line. It can end the burst by raising its stop line. The device ends the burst by itself when the local source has no word to give. In both cases the device lowers its request, releases the data lines and waits for the host to drop acknowledge. At that moment the host presents a CRC word on the data lines. The engine compares that word with its own CRC, which is kept over every word sent in the burst, and reports whether they match.

All host-side signals are taken as logical levels (1 = asserted). Any pin inversion is left to the pad ring. The bench assumes a 125 MHz clock, so the defaults give a spacing of 4 cycles between strobe transitions.

Top module: `udma_din_engine`

## Requirements
- R1: While reset is held and just after its release, dmarq=0, ddOe=0, devStrobe=1, srcReady=0 and crcErr=0.
- R2: dmarq rises only when a source word is pending while dmack=0. The data lines stay undriven (ddOe=0) and no strobe transition occurs until dmack=1, stop=0 and hostReady=1 are seen together.
- R3: Every strobe transition carries exactly one word, and ddOut is stable across it. Words leave in source order. The first transition of each burst is a falling edge (devStrobe 1 to 0).
- R4: Two consecutive strobe transitions are at least EDGE_CYC clock cycles apart. EDGE_CYC is the larger of ceil(25 ns / Tclk) and ceil(ceil(57 ns / Tclk) / 2), which is 4 at 8 ns.
- R5: The first strobe transition of a burst comes no more than 15 cycles (120 ns) after the host's start conditions are met.
- R6: While hostReady=0, no strobe transition starts. Transfer resumes when hostReady returns to 1.
- R7: After stop=1 is sampled, no further strobe transition occurs and dmarq falls on the next cycle.
- R8: When the source is empty at the moment the next word is needed, dmarq falls and strobing stops. Until dmack falls, the engine ignores stop and hostReady: there are no transitions and no new request.
- R9: The CRC uses x^16+x^12+x^5+1 and is processed MSB first. It is seeded with 4ABAh at each request and updated with every word sent. In the cycle dmack is first seen at 0 after a burst, ddIn is compared with the CRC. crcErr is set to 1 on a mismatch and 0 on a match, and crcDone pulses once.
- R10: Once the burst has terminated, for either reason, ddOe=0 so that the host can drive the CRC word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcValid | input | 1 | Local source has a word |
| srcData | input | 16 | Local source word |
| srcReady | output | 1 | Word taken this cycle |
| dmarq | output | 1 | DMA request to the host |
| dmack | input | 1 | DMA acknowledge from the host |
| stop | input | 1 | Host request to end the burst |
| hostReady | input | 1 | Host ready to receive; 0 requests a pause |
| devStrobe | output | 1 | Device data strobe, one word per transition |
| ddOut | output | 16 | Data lines driven by the device |
| ddIn | input | 16 | Data lines as driven by the host (CRC word) |
| ddOe | output | 1 | Device drives the data lines |
| crcErr | output | 1 | Result of the last CRC comparison, 1 = mismatch |
| crcDone | output | 1 | One-cycle pulse when a comparison is made |

## Verification
The assertions are checked on every cycle. They cover the minimum spacing of strobe transitions, the absence of transitions while the host pauses or after it asks to stop, and the quiet strobe and held-off request after the device's own termination. They also cover the start condition for driving the bus and the timing of the CRC pulse against the acknowledge drop. Some things only the bench scenarios can show: that the words reach the host in order and with the right values, that the CRC result is correct for good and corrupted closing words, that the first edge falls within its latency bound, and that a pending word does not raise a request while acknowledge is still high.

// File: rtl/udma_pkg.sv
package udma_pkg;

  localparam int          WORD_W   = 16;
  localparam logic [15:0] CRC_SEED = 16'h4ABA;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_SEND,
    ST_END
  } burstState_t;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic seedCrc;
    logic loadWord;
    logic toggle;
    logic closeBurst;
  } dpCtl_t;

  // One word through the CRC, most significant bit first.
  function automatic logic [15:0] crcNext(input logic [15:0] cur,
                                          input logic [WORD_W-1:0] word);
    logic [15:0] c;
    logic        fb;
    c = cur;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[15] ^ word[i];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction

endpackage

// File: rtl/udma_ctrl.sv
module udma_ctrl
  import udma_pkg::*;
#(
  parameter int EDGE_CYC = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   srcValid,
  input  logic   dmack,
  input  logic   stop,
  input  logic   hostReady,
  input  logic   hasWord,
  output logic   dmarq,
  output logic   ddOe,
  output logic   srcReady,
  output dpCtl_t ctl
);

  localparam int             GAP_W    = $clog2(EDGE_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(EDGE_CYC - 1);

  burstState_t      state, stateNxt;
  logic [GAP_W-1:0] gapCnt;
  logic             hostGo;
  logic             gapDone;

  assign hostGo  = dmack && !stop && hostReady;
  assign gapDone = (gapCnt == '0);

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (srcValid && !dmack) begin
          stateNxt    = ST_REQ;
          ctl.seedCrc = 1'b1;
        end
      end
      ST_REQ: begin
        if (hostGo) begin
          if (srcValid) begin
            ctl.loadWord = 1'b1;
            stateNxt     = ST_SEND;
          end else begin
            stateNxt = ST_END;
          end
        end
      end
      ST_SEND: begin
        if (!dmack || stop) begin
          stateNxt = ST_END;
        end else if (!hasWord) begin
          if (srcValid) ctl.loadWord = 1'b1;
          else          stateNxt     = ST_END;
        end else if (gapDone && hostReady) begin
          ctl.toggle = 1'b1;
        end
      end
      ST_END: begin
        if (!dmack) begin
          ctl.closeBurst = 1'b1;
          stateNxt       = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      state <= stateNxt;
      if (ctl.toggle || (ctl.loadWord && state == ST_REQ)) begin
        gapCnt <= GAP_LOAD;
      end else if (!gapDone) begin
        gapCnt <= gapCnt - GAP_W'(1);
      end
    end
  end

  assign dmarq    = (state == ST_REQ) || (state == ST_SEND);
  assign ddOe     = (state == ST_SEND);
  assign srcReady = ctl.loadWord;

endmodule

// File: rtl/udma_dpath.sv
module udma_dpath
  import udma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [WORD_W-1:0] srcData,
  input  logic [15:0]       ddIn,
  output logic [WORD_W-1:0] ddOut,
  output logic              devStrobe,
  output logic              hasWord,
  output logic              crcErr,
  output logic              crcDone
);

  logic [15:0] crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ddOut     <= '0;
      devStrobe <= 1'b1;
      hasWord   <= 1'b0;
      crcReg    <= CRC_SEED;
      crcErr    <= 1'b0;
      crcDone   <= 1'b0;
    end else begin
      crcDone <= ctl.closeBurst;
      if (ctl.seedCrc) begin
        crcReg  <= CRC_SEED;
        hasWord <= 1'b0;
      end
      if (ctl.loadWord) begin
        ddOut   <= srcData;
        hasWord <= 1'b1;
      end
      if (ctl.toggle) begin
        devStrobe <= ~devStrobe;
        hasWord   <= 1'b0;
        crcReg    <= crcNext(crcReg, ddOut);
      end
      if (ctl.closeBurst) begin
        devStrobe <= 1'b1;
        hasWord   <= 1'b0;
        crcErr    <= (ddIn != crcReg);
      end
    end
  end

endmodule

// File: rtl/udma_din_engine.sv
module udma_din_engine
  import udma_pkg::*;
#(
  parameter int CLK_PS     = 8000,
  parameter int T_CYC_PS   = 25000,
  parameter int T_2CYC_PS  = 57000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcValid,
  input  logic [WORD_W-1:0] srcData,
  output logic              srcReady,
  output logic              dmarq,
  input  logic              dmack,
  input  logic              stop,
  input  logic              hostReady,
  output logic              devStrobe,
  output logic [WORD_W-1:0] ddOut,
  input  logic [15:0]       ddIn,
  output logic              ddOe,
  output logic              crcErr,
  output logic              crcDone
);

  localparam int CYC_EDGE = (T_CYC_PS + CLK_PS - 1) / CLK_PS;
  localparam int CYC_PAIR = ((T_2CYC_PS + CLK_PS - 1) / CLK_PS + 1) / 2;
  localparam int EDGE_CYC = (CYC_EDGE > CYC_PAIR) ? CYC_EDGE : CYC_PAIR;

  dpCtl_t ctl;
  logic   hasWord;

  udma_ctrl #(.EDGE_CYC(EDGE_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srcValid (srcValid),
    .dmack    (dmack),
    .stop     (stop),
    .hostReady(hostReady),
    .hasWord  (hasWord),
    .dmarq    (dmarq),
    .ddOe     (ddOe),
    .srcReady (srcReady),
    .ctl      (ctl)
  );

  udma_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .srcData  (srcData),
    .ddIn     (ddIn),
    .ddOut    (ddOut),
    .devStrobe(devStrobe),
    .hasWord  (hasWord),
    .crcErr   (crcErr),
    .crcDone  (crcDone)
  );

endmodule

// File: rtl/udma_chk.sv
module udma_chk #(
  parameter int EDGE_CYC = 4
) (
  input logic clk,
  input logic rstN,
  input logic dmarq,
  input logic dmack,
  input logic stop,
  input logic hostReady,
  input logic devStrobe,
  input logic ddOe,
  input logic crcDone
);

  localparam int SW = $clog2(EDGE_CYC + 1);

  logic [SW-1:0] sinceEdge;
  logic          prevStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceEdge  <= SW'(EDGE_CYC);
      prevStrobe <= 1'b1;
    end else begin
      prevStrobe <= devStrobe;
      if (devStrobe != prevStrobe)      sinceEdge <= '0;
      else if (sinceEdge < SW'(EDGE_CYC)) sinceEdge <= sinceEdge + SW'(1);
    end
  end

  // R4: transitions are spaced by the minimum edge interval
  a_r4_edge_gap: assert property (@(posedge clk) disable iff (!rstN)
    (dmack && devStrobe != prevStrobe) |-> (int'(sinceEdge) >= EDGE_CYC - 1));

  // R2: bus is driven only after the host start conditions were seen
  a_r2_drive_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ddOe) |-> $past(dmack && !stop && hostReady));

  // R6: no transition starts while the host pauses
  a_r6_pause_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dmack && $past(dmack) && !$past(hostReady)) |-> $stable(devStrobe));

  // R7: no transition once stop was sampled
  a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dmack && $past(dmack) && $past(stop)) |-> $stable(devStrobe));

  // R7: request falls the cycle after stop is sampled in a burst
  a_r7_stop_drops_req: assert property (@(posedge clk) disable iff (!rstN)
    (dmarq && ddOe && stop && dmack) |=> !dmarq);

  // R8: after termination the request stays low while acknowledge is held
  a_r8_no_rerequest: assert property (@(posedge clk) disable iff (!rstN)
    (!dmarq && dmack) |=> !dmarq);

  // R8: strobe quiet after termination until acknowledge drops
  a_r8_quiet_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (dmack && !dmarq && $past(dmack && !dmarq)) |-> $stable(devStrobe));

  // R9: comparison pulse only follows a dropped acknowledge
  a_r9_crc_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    crcDone |-> !$past(dmack));

endmodule

bind udma_din_engine udma_chk #(.EDGE_CYC(EDGE_CYC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dmarq    (dmarq),
  .dmack    (dmack),
  .stop     (stop),
  .hostReady(hostReady),
  .devStrobe(devStrobe),
  .ddOe     (ddOe),
  .crcDone  (crcDone)
);

// File: tb/udma_din_engine_tb.sv
module udma_din_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srcValid;
  logic [15:0] srcData;
  logic        srcReady;
  logic        dmarq;
  logic        dmack = 1'b0;
  logic        stop = 1'b0;
  logic        hostReady = 1'b0;
  logic        devStrobe;
  logic [15:0] ddOut;
  logic [15:0] ddIn = 16'h0000;
  logic        ddOe;
  logic        crcErr;
  logic        crcDone;

  always #4 clk = ~clk;

  udma_din_engine u_dut (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcData(srcData),
    .srcReady(srcReady), .dmarq(dmarq), .dmack(dmack), .stop(stop),
    .hostReady(hostReady), .devStrobe(devStrobe), .ddOut(ddOut),
    .ddIn(ddIn), .ddOe(ddOe), .crcErr(crcErr), .crcDone(crcDone)
  );

  int errors = 0;
  int checks = 0;
  int cycCnt = 0;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  // local word source
  logic [15:0] srcMem [0:63];
  int srcIdx = 0;
  int srcEnd = 0;
  assign srcValid = (srcIdx < srcEnd);
  assign srcData  = srcMem[srcIdx % 64];
  always @(posedge clk) if (srcValid && srcReady) srcIdx <= srcIdx + 1;

  // host-side capture of each strobe transition
  logic [15:0] capMem  [0:63];
  int          edgeCyc [0:63];
  logic        edgeVal [0:63];
  int   capCnt = 0;
  int   lastEdgeCyc = -1000;
  int   gapViol = 0;
  int   doneCnt = 0;
  logic lastStrobe = 1'b1;
  always @(negedge clk) begin
    if (crcDone) doneCnt++;
    if (dmack && devStrobe !== lastStrobe) begin
      if (cycCnt - lastEdgeCyc < 4) begin
        gapViol++;
        $display("FAIL R4 edge spacing: actual=%0d expected>=4", cycCnt - lastEdgeCyc);
      end
      capMem[capCnt % 64]  = ddOut;
      edgeCyc[capCnt % 64] = cycCnt;
      edgeVal[capCnt % 64] = devStrobe;
      capCnt++;
      lastEdgeCyc = cycCnt;
    end
    lastStrobe = devStrobe;
  end

  // {words, pause after, host ends, corrupt crc}
  localparam logic [31:0] VECS [6] = '{
    {8'd6, 8'd0, 8'd1, 8'd0},
    {8'd5, 8'd0, 8'd0, 8'd0},
    {8'd9, 8'd3, 8'd1, 8'd0},
    {8'd4, 8'd2, 8'd0, 8'd1},
    {8'd1, 8'd0, 8'd0, 8'd0},
    {8'd2, 8'd1, 8'd1, 8'd1}
  };

  function automatic logic [15:0] crcRef(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    r = c;
    for (int b = 15; b >= 0; b--) begin
      if (r[15] ^ w[b]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic runBurst(input int n, input int pauseAt, input bit hostEnd,
                          input bit badCrc, input int seed);
    int base, capStart, doneStart, t, accCyc;
    logic [15:0] c;
    bit ok;
    base      = srcIdx;
    capStart  = capCnt;
    doneStart = doneCnt;
    for (int i = 0; i < n + 4; i++)
      srcMem[(base + i) % 64] = 16'(seed * 40503) ^ 16'(i * 15471) ^ 16'h5A00;
    srcEnd = base + (hostEnd ? n + 4 : n);
    t = 0;
    while (!dmarq && t < 100) begin @(negedge clk); t++; end
    chk("R2 request raised", dmarq, 1);
    chk("R2 bus idle before acknowledge", ddOe, 0);
    dmack = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no drive before host ready", ddOe, 0);
    chk("R2 no word before host ready", capCnt - capStart, 0);
    hostReady = 1'b1;
    accCyc = cycCnt;
    if (pauseAt > 0) begin
      t = 0;
      while (capCnt - capStart < pauseAt && t < 500) begin @(negedge clk); t++; end
      hostReady = 1'b0;
      repeat (12) @(negedge clk);
      chk("R6 no words during pause", capCnt - capStart, pauseAt);
      hostReady = 1'b1;
    end
    if (hostEnd) begin
      t = 0;
      while (capCnt - capStart < n && t < 2000) begin @(negedge clk); t++; end
      hostReady = 1'b0;
      repeat (3) @(negedge clk);
      stop = 1'b1;
      repeat (2) @(negedge clk);
      chk("R7 request dropped after stop", dmarq, 0);
      hostReady = 1'b1;
      repeat (6) @(negedge clk);
      chk("R7 no word after stop", capCnt - capStart, n);
      srcEnd = srcIdx;
    end else begin
      t = 0;
      while (dmarq && t < 2000) begin @(negedge clk); t++; end
      chk("R8 request dropped on empty source", dmarq, 0);
      chk("R8 all words sent", capCnt - capStart, n);
      stop = 1'b1;
      hostReady = 1'b0;
      repeat (3) @(negedge clk);
      hostReady = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 host lines ignored after end", capCnt - capStart, n);
      chk("R8 no new request before ack drop", dmarq, 0);
    end
    chk("R10 bus released at end", ddOe, 0);
    c = 16'h4ABA;
    for (int i = 0; i < n; i++) c = crcRef(c, srcMem[(base + i) % 64]);
    ddIn = badCrc ? (c ^ 16'h0100) : c;
    @(negedge clk);
    dmack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 crc compare result", crcErr, badCrc);
    chk("R9 one compare pulse", doneCnt - doneStart, 1);
    ok = 1'b1;
    for (int i = 0; i < n; i++)
      if (capMem[(capStart + i) % 64] !== srcMem[(base + i) % 64]) ok = 1'b0;
    chk("R3 words in source order", ok, 1);
    chk("R3 first edge falling", edgeVal[capStart % 64], 0);
    chk("R5 first edge latency within 15", (edgeCyc[capStart % 64] - accCyc) <= 15, 1);
    stop = 1'b0;
    hostReady = 1'b0;
    ddIn = 16'h0000;
    repeat (2) @(negedge clk);
  endtask

  task automatic runAll();
    repeat (3) @(negedge clk);
    chk("R1 dmarq in reset", dmarq, 0);
    chk("R1 ddOe in reset", ddOe, 0);
    chk("R1 devStrobe in reset", devStrobe, 1);
    chk("R1 srcReady in reset", srcReady, 0);
    chk("R1 crcErr in reset", crcErr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 dmarq after reset", dmarq, 0);
    chk("R1 devStrobe after reset", devStrobe, 1);
    // pending word while acknowledge is already high: no request
    dmack = 1'b1;
    srcMem[srcIdx % 64] = 16'h1234;
    srcEnd = srcIdx + 1;
    repeat (5) @(negedge clk);
    chk("R2 no request while ack high", dmarq, 0);
    dmack = 1'b0;
    for (int v = 0; v < 6; v++)
      runBurst(int'(VECS[v][31:24]), int'(VECS[v][23:16]), VECS[v][8], VECS[v][0], v + 1);
    chk("R4 edge spacing violations", gapViol, 0);
  endtask

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) chk("watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule